// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks a single reservation so that a core can build an atomic read-modify-write from two operations. The first is a load-linked, which reads memory and records the word it touched. The second is a store-conditional, which writes memory only if that reservation is still intact. Between the two, the reservation can be lost. An exception return discards it. A write by another bus master to the same word also discards it, and the snoop port reports such writes.

In the cycle of a store-conditional the block decides whether the store may proceed. It drives the gated memory write enable combinationally in that same cycle. One cycle later it presents a registered success flag and the value that goes to the destination register: 1 on success and 0 on failure, zero-extended. Addresses are compared at word granularity. Every store-conditional consumes the reservation, whether it succeeds or fails.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held. A store-conditional issued before any load-linked fails, and scSuccess and memWe are both 0 during reset.
- R2: A load-linked to a word followed by a store-conditional to the same word succeeds. memWe is 1 in the store-conditional cycle, scSuccess is 1 in the next cycle, and scResult is 1 in the next cycle.
- R3: A store-conditional fails when no load-linked has been recorded since the last clearing event.
- R4: Addresses match when bits [ADDR_W-1:2] are equal. The low two byte-offset bits are ignored. A store-conditional to a different word fails.
- R5: An exception-return pulse clears the reservation, so a following store-conditional fails.
- R6: A snoop write (snoopValid=1) to the linked word clears the reservation. A snoop write to any other word leaves it intact.
- R7: When a store-conditional fails, memWe stays 0 in that cycle.
- R8: Every store-conditional clears the reservation, whether it succeeds or fails. A second store-conditional with no new load-linked fails.
- R9: A new load-linked replaces any earlier reservation, including its address.
- R10: scSuccess and scResult are registered. They reflect the store-conditional of the previous cycle, and scResult carries 1 or 0 zero-extended to DATA_W bits. In a cycle that follows no store-conditional, both are 0.
- R11: Same-cycle ordering follows three rules:
  - A store-conditional that coincides with an exception return fails.
  - A store-conditional that coincides with a snoop write to the linked word fails.
  - When a load-linked and a store-conditional coincide, the store-conditional is judged against the prior reservation, and the load-linked installs a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| llValid | input | 1 | Load-linked event this cycle |
| llAddr | input | ADDR_W | Byte address of the load-linked |
| scValid | input | 1 | Store-conditional request this cycle |
| scAddr | input | ADDR_W | Byte address of the store-conditional |
| eretPulse | input | 1 | Exception return this cycle |
| snoopValid | input | 1 | Another master writes memory this cycle |
| snoopAddr | input | ADDR_W | Byte address of the snooped write |
| memWe | output | 1 | Gated memory write enable for the store-conditional |
| scSuccess | output | 1 | Registered success flag of the previous store-conditional |
| scResult | output | DATA_W | Value for the destination register, 1 or 0 |

## Verification
Directed sequences pair each clearing event with an otherwise successful load-linked/store-conditional pair, so that a failure can be traced to that event alone. Three contrasts are tested:
- a snoop to the linked word against a snoop to a neighbouring word;
- byte offsets within the linked word against an adjacent word;
- an old reservation against one that a newer load-linked has replaced.

Same-cycle collisions of the store-conditional with an exception return, a snoop write and a load-linked show the ordering rules. Seeded random traffic over a four-word address pool then mixes all events against a reference model in the bench.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadLink;   // capture a new linked word
    logic dropLink;   // reservation is lost this cycle
    logic commit;     // store-conditional is allowed to write
  } linkCtrl_t;

endpackage

// File: rtl/llsc_word_match.sv
module llsc_word_match #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 2,
  localparam int TAG_W   = ADDR_W - OFFSET_W
) (
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic [TAG_W-1:0]  linkTag,
  output logic              wordHit
);

  always_comb begin
    wordHit = (probeAddr[ADDR_W-1:OFFSET_W] == linkTag);
  end

endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 2,
  localparam int TAG_W   = ADDR_W - OFFSET_W,
  localparam int N_PROBE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  linkCtrl_t         ctrl,
  output logic              scHit,
  output logic              snoopHit,
  output logic              scSuccess,
  output logic [DATA_W-1:0] scResult
);

  logic [TAG_W-1:0]  linkTag;
  logic [ADDR_W-1:0] probeAddr [N_PROBE];
  logic [N_PROBE-1:0] probeHit;

  // Linked word register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkTag <= '0;
    end else if (ctrl.loadLink) begin
      linkTag <= llAddr[ADDR_W-1:OFFSET_W];
    end
  end

  assign probeAddr[0] = scAddr;
  assign probeAddr[1] = snoopAddr;

  for (genvar p = 0; p < N_PROBE; p++) begin : g_probe
    llsc_word_match #(
      .ADDR_W   (ADDR_W),
      .OFFSET_W (OFFSET_W)
    ) u_match (
      .probeAddr (probeAddr[p]),
      .linkTag   (linkTag),
      .wordHit   (probeHit[p])
    );
  end

  assign scHit    = probeHit[0];
  assign snoopHit = probeHit[1];

  // Registered result toward the register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scSuccess <= 1'b0;
      scResult  <= '0;
    end else begin
      scSuccess <= ctrl.commit;
      scResult  <= DATA_W'(ctrl.commit);
    end
  end

endmodule

// File: rtl/llsc_control.sv
module llsc_control
  import llsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      llValid,
  input  logic      scValid,
  input  logic      eretPulse,
  input  logic      snoopValid,
  input  logic      scHit,
  input  logic      snoopHit,
  output linkCtrl_t ctrl
);

  logic linkValid;
  logic snoopBreak;

  always_comb begin
    snoopBreak    = snoopValid & snoopHit;
    ctrl.loadLink = llValid;
    // Judged against the reservation held before this edge
    ctrl.commit   = scValid & linkValid & scHit & ~eretPulse & ~snoopBreak;
    ctrl.dropLink = scValid | eretPulse | (snoopBreak & linkValid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
    end else if (ctrl.loadLink) begin
      linkValid <= 1'b1;
    end else if (ctrl.dropLink) begin
      linkValid <= 1'b0;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              llValid,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic              eretPulse,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              memWe,
  output logic              scSuccess,
  output logic [DATA_W-1:0] scResult
);

  linkCtrl_t ctrl;
  logic      scHit;
  logic      snoopHit;

  llsc_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .llValid    (llValid),
    .scValid    (scValid),
    .eretPulse  (eretPulse),
    .snoopValid (snoopValid),
    .scHit      (scHit),
    .snoopHit   (snoopHit),
    .ctrl       (ctrl)
  );

  llsc_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFFSET_W (OFFSET_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .llAddr    (llAddr),
    .scAddr    (scAddr),
    .snoopAddr (snoopAddr),
    .ctrl      (ctrl),
    .scHit     (scHit),
    .snoopHit  (snoopHit),
    .scSuccess (scSuccess),
    .scResult  (scResult)
  );

  assign memWe = ctrl.commit;

endmodule

// File: rtl/llsc_monitor_checker.sv
module llsc_monitor_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              llValid,
  input logic              scValid,
  input logic              eretPulse,
  input logic              memWe,
  input logic              scSuccess,
  input logic [DATA_W-1:0] scResult
);

  a_r7_we_needs_sc: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> scValid);

  a_r2_success_follows_we: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (scSuccess && scResult == DATA_W'(1)));

  a_r7_fail_reports_zero: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !memWe) |=> (!scSuccess && scResult == '0));

  a_r10_idle_no_success: assert property (@(posedge clk) disable iff (!rstN)
    !scValid |=> !scSuccess);

  a_r5_eret_clears: assert property (@(posedge clk) disable iff (!rstN)
    (eretPulse && !llValid) |=> !memWe);

  a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !llValid) |=> !memWe);

  a_r11_eret_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && eretPulse) |-> !memWe);

endmodule

bind llsc_monitor llsc_monitor_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .llValid   (llValid),
  .scValid   (scValid),
  .eretPulse (eretPulse),
  .memWe     (memWe),
  .scSuccess (scSuccess),
  .scResult  (scResult)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              llValid, scValid, eretPulse, snoopValid;
  logic [ADDR_W-1:0] llAddr, scAddr, snoopAddr;
  logic              memWe, scSuccess;
  logic [DATA_W-1:0] scResult;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        refLink = 1'b0;
  logic [29:0] refTag = '0;

  always #10 clk = ~clk;

  llsc_monitor u_llsc_monitor (
    .clk(clk), .rstN(rstN),
    .llValid(llValid), .llAddr(llAddr),
    .scValid(scValid), .scAddr(scAddr),
    .eretPulse(eretPulse),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .memWe(memWe), .scSuccess(scSuccess), .scResult(scResult)
  );

  localparam logic [31:0] WA = 32'h1000_0040;
  localparam logic [31:0] WB = 32'h1000_0044;

  function automatic logic sameWord(input logic [31:0] a, input logic [29:0] t);
    return a[31:2] == t;
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks both outputs
  task automatic step(input logic ll, input logic [31:0] la,
                      input logic sc, input logic [31:0] sa,
                      input logic er, input logic sv, input logic [31:0] na,
                      input string req);
    logic expWe, snHit;
    llValid = ll; llAddr = la; scValid = sc; scAddr = sa;
    eretPulse = er; snoopValid = sv; snoopAddr = na;
    #1;
    snHit = sv && sameWord(na, refTag);
    expWe = sc && refLink && sameWord(sa, refTag) && !er && !snHit;
    cmp({31'b0, memWe}, {31'b0, expWe}, {req, " memWe"});
    if (ll) begin
      refLink = 1'b1; refTag = la[31:2];
    end else if (sc || er || (snHit && refLink)) begin
      refLink = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    cmp({31'b0, scSuccess}, {31'b0, expWe}, {req, " scSuccess"});
    cmp(scResult, {31'b0, expWe}, {req, " scResult"});
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0;
    llValid = 0; scValid = 0; eretPulse = 0; snoopValid = 0;
    llAddr = 0; scAddr = 0; snoopAddr = 0;
    repeat (3) @(negedge clk);
    cmp({31'b0, scSuccess}, 32'd0, "R1 reset scSuccess");
    cmp({31'b0, memWe}, 32'd0, "R1 reset memWe");
    rstN = 1'b1;

    // R1: no reservation after reset
    step(0, 0, 1, WA, 0, 0, 0, "R1 sc after reset");
    // R2: basic pair
    step(1, WA, 0, 0, 0, 0, 0, "R2 ll");
    step(0, 0, 1, WA, 0, 0, 0, "R2 sc");
    idle("R10 idle after sc");
    // R3: sc with nothing linked
    step(0, 0, 1, WB, 0, 0, 0, "R3 sc unlinked");
    // R4: byte offsets ignored, other word fails
    step(1, WA + 1, 0, 0, 0, 0, 0, "R4 ll offset");
    step(0, 0, 1, WA + 3, 0, 0, 0, "R4 sc same word");
    step(1, WA, 0, 0, 0, 0, 0, "R4 ll");
    step(0, 0, 1, WB, 0, 0, 0, "R4 sc other word");
    // R5: exception return between
    step(1, WA, 0, 0, 0, 0, 0, "R5 ll");
    step(0, 0, 0, 0, 1, 0, 0, "R5 eret");
    step(0, 0, 1, WA, 0, 0, 0, "R5 sc");
    // R6: snoop to linked word vs other word
    step(1, WA, 0, 0, 0, 0, 0, "R6 ll");
    step(0, 0, 0, 0, 0, 1, WA + 2, "R6 snoop hit");
    step(0, 0, 1, WA, 0, 0, 0, "R6 sc after hit");
    step(1, WA, 0, 0, 0, 0, 0, "R6 ll");
    step(0, 0, 0, 0, 0, 1, WB, "R6 snoop miss");
    step(0, 0, 1, WA, 0, 0, 0, "R6 sc after miss");
    // R8: second sc fails
    step(1, WB, 0, 0, 0, 0, 0, "R8 ll");
    step(0, 0, 1, WB, 0, 0, 0, "R8 first sc");
    step(0, 0, 1, WB, 0, 0, 0, "R8 second sc");
    // R9: replacement
    step(1, WA, 0, 0, 0, 0, 0, "R9 ll old");
    step(1, WB, 0, 0, 0, 0, 0, "R9 ll new");
    step(0, 0, 1, WA, 0, 0, 0, "R9 sc old word");
    step(1, WA, 0, 0, 0, 0, 0, "R9 ll old");
    step(1, WB, 0, 0, 0, 0, 0, "R9 ll new");
    step(0, 0, 1, WB, 0, 0, 0, "R9 sc new word");
    // R11: same-cycle ordering
    step(1, WA, 0, 0, 0, 0, 0, "R11 ll");
    step(0, 0, 1, WA, 1, 0, 0, "R11 sc with eret");
    step(1, WA, 0, 0, 0, 0, 0, "R11 ll");
    step(0, 0, 1, WA, 0, 1, WA, "R11 sc with snoop");
    step(1, WA, 0, 0, 0, 0, 0, "R11 ll");
    step(1, WB, 1, WA, 0, 0, 0, "R11 sc with ll");
    step(0, 0, 1, WB, 0, 0, 0, "R11 sc on new link");
    // R7: failed sc never writes (memWe checked in every step)
    step(0, 0, 1, WA, 0, 0, 0, "R7 failing sc");

    // Seeded random traffic
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [31:0] la, sa, na;
      r  = $urandom;
      la = WA + {26'b0, 2'(($urandom) % 4), 2'($urandom)};
      sa = WA + {26'b0, 2'(($urandom) % 4), 2'($urandom)};
      na = WA + {26'b0, 2'(($urandom) % 4), 2'($urandom)};
      step(r[2:0] < 3'd2, la, r[5:3] < 3'd3, sa, r[9:6] == 4'd0,
           r[12:10] < 3'd2, na, "R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule